// File: doc/BRIEF.md
# Write-Busy Polling Read Responder

This block builds the byte a host sees when it reads a nonvolatile memory while an internal programming cycle may be running. The write controller supplies a busy flag and the last byte it accepted. The array supplies ordinary read data. The host signals a read by pulling chip-enable and output-enable low together. The block then drives the data bus and produces a matching bus-enable for the pad tri-state.

While the memory is busy, every read returns a status word instead of array contents. Bit 7 is the complement of bit 7 of the last byte written. Bit 6 flips from one busy read to the next. Bits 5..0 read as zero. Once the programming cycle ends, reads return array data unchanged. The host can therefore detect the end of a write with either of two polls: compare bit 7 against its own data, or read twice and compare bit 6. No separate ready pin is needed.

A write-permit output stays low while busy and for a fixed recovery window after busy falls. It tells the write path when a new write may begin.

Top module: `poll_resp`

## Requirements
- R1: `data_oe_o` is 1 exactly when `ce_ni` and `oe_ni` are both 0, and 0 whenever either is 1.
- R2: The read word is captured at the first clock edge at which the read strobe is seen active. `data_o` shows it from that edge on and holds it unchanged for the rest of the read, even if the inputs change.
- R3: A read captured while `busy_i`=1 returns bit 7 equal to the inverse of `last_data_i[7]`.
- R4: Two successive reads captured while `busy_i`=1 return opposite values on bit 6.
- R5: A read captured while `busy_i`=1 returns 0 on bits 5..0.
- R6: A read captured while `busy_i`=0 returns `arr_data_i` on all 8 bits.
- R7: The bit-6 toggle advances only on busy reads. Non-busy reads and idle cycles between two busy reads do not change the alternation.
- R8: `wr_ok_o` is 0 while `busy_i`=1. After `busy_i` falls it stays 0 for exactly `RECOV_CYC`-1 clock edges and becomes 1 at the `RECOV_CYC`-th edge.
- R9: After reset with strobes idle, `data_o`=0, `data_oe_o`=0 and `wr_ok_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| busy_i | input | 1 | Programming cycle in progress |
| last_data_i | input | 8 | Last byte accepted by the write controller |
| arr_data_i | input | 8 | Array read data |
| data_o | output | 8 | Read data bus value |
| data_oe_o | output | 1 | Bus drive enable (0 = high impedance) |
| wr_ok_o | output | 1 | Recovery window has elapsed; a new write may start |

## Verification
The hardest case to reach from the ports is R7. Non-busy reads are interleaved between busy reads, and the toggle must neither advance nor reset across them. The toggle's absolute value is never visible, so the bench remembers the bit 6 of the last busy read. Random traffic then mixes busy and idle reads and checks each new busy read against that remembered value. A directed sequence counts edges from the fall of busy to reach the exact recovery boundary.

// File: rtl/poll_resp_pkg.sv
package poll_resp_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned RSV_W    = 6;
endpackage

// File: rtl/rd_strobe_det.sv
module rd_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  output logic rd_o,
  output logic start_o
);
  logic rd_q;
  assign rd_o    = ~ce_ni & ~oe_ni;
  assign start_o = rd_o & ~rd_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_o;
endmodule

// File: rtl/toggle_gen.sv
module toggle_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    tog_o <= 1'b0;
    else if (adv_i) tog_o <= ~tog_o;
endmodule

// File: rtl/recov_timer.sv
module recov_timer #(
  parameter int unsigned RECOV_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(RECOV_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(RECOV_CYC);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= LIM;
    else if (busy_i)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  assign ok_o = ~busy_i & (cnt_q == LIM);
endmodule

// File: rtl/poll_resp.sv
module poll_resp
  import poll_resp_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          busy_i,
  input  logic [DW-1:0] last_data_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          wr_ok_o
);
  logic rd, start, tog;
  logic [DW-1:0] stat_w, data_q;

  rd_strobe_det u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni),
    .rd_o(rd), .start_o(start)
  );

  toggle_gen u_tog (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(start & busy_i), .tog_o(tog)
  );

  recov_timer #(.RECOV_CYC(RECOV_CYC)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .ok_o(wr_ok_o)
  );

  always_comb begin
    stat_w           = '0;
    stat_w[POLL_BIT] = ~last_data_i[POLL_BIT];
    stat_w[TOG_BIT]  = tog;
  end

  // status word replaces array data for the whole of a busy read
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    data_q <= '0;
    else if (start) data_q <= busy_i ? stat_w : arr_data_i;

  assign data_o    = data_q;
  assign data_oe_o = rd;
endmodule

// File: rtl/poll_resp_chk.sv
module poll_resp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic [7:0] last_data_i,
  input logic [7:0] arr_data_i,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       wr_ok_o
);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |=> (data_oe_o -> $stable(data_o)));
  assert_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(data_oe_o) && busy_i) |-> ##1 (data_o[7] == ~$past(last_data_i[7])));
  assert_rsv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(data_oe_o) && busy_i) |=> (data_o[5:0] == 6'd0));
  assert_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(data_oe_o) && !busy_i) |=> (data_o == $past(arr_data_i)));
  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !wr_ok_o);
endmodule

bind poll_resp poll_resp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .last_data_i(last_data_i),
  .arr_data_i(arr_data_i), .data_o(data_o), .data_oe_o(data_oe_o), .wr_ok_o(wr_ok_o)
);

// File: tb/poll_resp_tb.sv
module poll_resp_tb;
  localparam int RC = 1000;
  logic clk_i = 0, rst_ni = 0, ce_ni = 1, oe_ni = 1, busy_i = 0;
  logic [7:0] last_data_i = 0, arr_data_i = 0, data_o;
  logic data_oe_o, wr_ok_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, have_prev = 0, prev_tog = 0;

  always #5 clk_i = ~clk_i;

  poll_resp #(.RECOV_CYC(RC)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input bit b, input logic [7:0] l,
                                          input logic [7:0] a, input bit t);
    return b ? {~l[7], t, 6'd0} : a;
  endfunction

  task automatic do_read(input bit b, input logic [7:0] l, input logic [7:0] a);
    logic [7:0] e, first;
    bit t;
    @(negedge clk_i);
    busy_i = b; last_data_i = l; arr_data_i = a;
    ce_ni = 0; oe_ni = 0;
    #1 chk(data_oe_o == 1, "R1 oe on", data_oe_o, 1);
    @(negedge clk_i);
    first = data_o;
    t = have_prev ? ~prev_tog : data_o[6];
    e = exp_word(b, l, a, t);
    if (b) begin
      chk(data_o[7] == e[7], "R3 poll bit", data_o[7], e[7]);
      chk(data_o[5:0] == 0, "R5 reserved", data_o[5:0], 0);
      if (have_prev) chk(data_o[6] == t, "R4/R7 toggle", data_o[6], t);
      chk(wr_ok_o == 0, "R8 busy no write", wr_ok_o, 0);
      prev_tog = data_o[6]; have_prev = 1;
    end else chk(data_o == a, "R6 passthrough", data_o, a);
    arr_data_i = ~a; last_data_i = ~l;
    @(negedge clk_i);
    chk(data_o == first, "R2 hold", data_o, first);
    if ($urandom_range(1, 0) == 1) ce_ni = 1; else oe_ni = 1;
    #1 chk(data_oe_o == 0, "R1 oe off", data_oe_o, 0);
    ce_ni = 1; oe_ni = 1;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(data_o == 0, "R9 data reset", data_o, 0);
    chk(data_oe_o == 0, "R9 oe reset", data_oe_o, 0);
    chk(wr_ok_o == 1, "R9 wr_ok reset", wr_ok_o, 1);
    // directed: toggle alternation across non-busy reads (R7)
    do_read(1, 8'h00, 8'h11);
    do_read(1, 8'h80, 8'h22);
    do_read(0, 8'h00, 8'hA5);
    do_read(0, 8'h00, 8'h5A);
    do_read(1, 8'h7F, 8'h33);
    do_read(1, 8'hFF, 8'hFF);
    // random mix
    for (int i = 0; i < 300; i++) begin
      do_read($urandom_range(1, 0) == 1, 8'($urandom), 8'($urandom));
      repeat ($urandom_range(3, 0)) @(negedge clk_i);
    end
    // recovery window (R8)
    @(negedge clk_i); busy_i = 1;
    @(negedge clk_i);
    chk(wr_ok_o == 0, "R8 low while busy", wr_ok_o, 0);
    busy_i = 0;
    repeat (RC - 1) @(negedge clk_i);
    chk(wr_ok_o == 0, "R8 low before window end", wr_ok_o, 0);
    @(negedge clk_i);
    chk(wr_ok_o == 1, "R8 high at window end", wr_ok_o, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule